// File: doc/BRIEF.md
# RV32I Control-Transfer Unit

This block resolves the control-transfer instructions of a 32-bit RISC-V integer core. Each cycle that the decoder presents a valid instruction, the block takes the current program counter, both register operands, the raw immediate field and a class and condition code. On the next clock edge it presents the address to fetch next, a flag saying whether control left the sequential path, and the return address together with its write enable.

Conditional branches compare the two operands as signed or unsigned values. A true condition sends control to the PC plus an offset whose lowest bit is implied zero. JAL adds a longer PC-relative offset. JALR adds a short immediate to the first operand and clears bit 0 of the sum. Both jumps hand back PC+4 for the destination register. Anything else, and any branch that is not taken, continues at PC+4.

Top module: `rv_xfer_unit`

## Requirements
- R1: While reset is held, and until the first valid input, out_valid, taken and link_we are 0, link_val is 0 and next_pc equals RESET_PC (default 0).
- R2: For a branch (class 2'b01) with cond 3'b000 (equal) or 3'b001 (not equal), a true condition gives taken=1 and next_pc = pc + offset; otherwise taken=0 and next_pc = pc+4.
- R3: cond 3'b100 (less than) and 3'b101 (greater or equal) compare rs1_val against rs2_val as two's-complement values.
- R4: cond 3'b110 (less than) and 3'b111 (greater or equal) compare rs1_val against rs2_val as unsigned values.
- R5: The branch offset is imm_field[11:0] taken as offset bits 12..1, with bit 0 zero and sign taken from imm_field[11]. The range is -4096 to +4094.
- R6: A JAL (class 2'b10) always has taken=1 and next_pc = pc + offset, where imm_field[19:0] supplies offset bits 20..1, bit 0 is zero and the value is sign-extended.
- R7: A JALR (class 2'b11) always has taken=1 and next_pc = (rs1_val + sign-extended imm_field[11:0]) with bit 0 forced to 0.
- R8: JAL and JALR give link_we=1 and link_val = pc+4. Branches and non-transfer inputs give link_we=0.
- R9: A non-transfer input (class 2'b00) gives taken=0 and next_pc = pc+4.
- R10: Branch condition codes 3'b010 and 3'b011 are never taken.
- R11: All outputs are registered. They reflect an input one clock edge after in_valid=1. When in_valid=0 at an edge, out_valid goes to 0 and next_pc, taken, link_val and link_we hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input fields carry an instruction this cycle |
| pc | input | 32 | Address of the current instruction |
| rs1_val | input | 32 | First register operand (JALR base) |
| rs2_val | input | 32 | Second register operand |
| imm_field | input | 20 | Raw immediate field, interpreted per class |
| xfer_class | input | 2 | 00 none, 01 branch, 10 JAL, 11 JALR |
| cond | input | 3 | Branch condition code |
| out_valid | output | 1 | Registered outputs belong to an input |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Control left the sequential path |
| link_val | output | 32 | Return address PC+4 |
| link_we | output | 1 | Write link_val to the destination register |

## Verification
Every result of this block is due exactly one rising edge after the input that produced it, because there is a single register stage between the inputs and all five outputs. The bench drives each input on the falling edge, waits for the next rising edge, and samples 1 ns later. Every output is therefore compared in the cycle its register loads. For the hold behaviour, the bench changes the inputs with in_valid low and samples after the following edge. It expects the previous values at that point, and expects out_valid to be low.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    XC_NONE   = 2'b00,
    XC_BRANCH = 2'b01,
    XC_JAL    = 2'b10,
    XC_JALR   = 2'b11
  } xfer_class_e;

  // Condition codes follow the funct3 field the decoder forwards.
  localparam logic [2:0] CC_EQ  = 3'b000;
  localparam logic [2:0] CC_NE  = 3'b001;
  localparam logic [2:0] CC_LT  = 3'b100;
  localparam logic [2:0] CC_GE  = 3'b101;
  localparam logic [2:0] CC_LTU = 3'b110;
  localparam logic [2:0] CC_GEU = 3'b111;

endpackage

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval #(
  parameter int XLEN    = 32,
  parameter bit CMP_SUB = 1'b1
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [2:0]      cond,
  output logic            op_eq,
  output logic            op_lt_s,
  output logic            op_lt_u,
  output logic            cond_true
);
  import xfer_pkg::*;

  assign op_eq = (opa == opb);

  generate
    if (CMP_SUB) begin : g_sub
      // One shared subtractor; the borrow gives the unsigned order and
      // the sign bits select between it and the signed order.
      logic [XLEN:0] diff;
      assign diff    = {1'b0, opa} - {1'b0, opb};
      assign op_lt_u = diff[XLEN];
      assign op_lt_s = (opa[XLEN-1] ^ opb[XLEN-1]) ? opa[XLEN-1] : diff[XLEN];
    end else begin : g_native
      assign op_lt_u = (opa < opb);
      assign op_lt_s = ($signed(opa) < $signed(opb));
    end
  endgenerate

  always_comb begin
    unique case (cond)
      CC_EQ:   cond_true = op_eq;
      CC_NE:   cond_true = !op_eq;
      CC_LT:   cond_true = op_lt_s;
      CC_GE:   cond_true = !op_lt_s;
      CC_LTU:  cond_true = op_lt_u;
      CC_GEU:  cond_true = !op_lt_u;
      default: cond_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/xfer_target_gen.sv
module xfer_target_gen #(
  parameter int XLEN       = 32,
  parameter int BR_IMM_W   = 12,
  parameter int J_IMM_W    = 20,
  parameter int I_IMM_W    = 12,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    base,
  input  logic [J_IMM_W-1:0] imm_field,
  input  logic [1:0]         xclass,
  input  logic               cond_true,
  output logic [XLEN-1:0]    seq_pc,
  output logic [XLEN-1:0]    pcrel_tgt,
  output logic [XLEN-1:0]    reg_tgt,
  output logic [XLEN-1:0]    target,
  output logic               redirect,
  output logic               link_en
);
  import xfer_pkg::*;

  localparam int BR_PAD = XLEN - BR_IMM_W - 1;
  localparam int J_PAD  = XLEN - J_IMM_W - 1;
  localparam int I_PAD  = XLEN - I_IMM_W;

  function automatic logic [XLEN-1:0] sext_branch(input logic [J_IMM_W-1:0] f);
    logic [BR_IMM_W-1:0] fld;
    fld = f[BR_IMM_W-1:0];
    return {{BR_PAD{fld[BR_IMM_W-1]}}, fld, 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] sext_jump(input logic [J_IMM_W-1:0] f);
    return {{J_PAD{f[J_IMM_W-1]}}, f, 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] sext_reg(input logic [J_IMM_W-1:0] f);
    logic [I_IMM_W-1:0] fld;
    fld = f[I_IMM_W-1:0];
    return {{I_PAD{fld[I_IMM_W-1]}}, fld};
  endfunction

  function automatic logic [XLEN-1:0] clear_lsb(input logic [XLEN-1:0] v);
    return {v[XLEN-1:1], 1'b0};
  endfunction

  logic [XLEN-1:0] pc_off;
  logic [XLEN-1:0] reg_sum;

  assign seq_pc  = pc + XLEN'(INSN_BYTES);
  assign pc_off  = (xclass == XC_JAL) ? sext_jump(imm_field) : sext_branch(imm_field);
  assign pcrel_tgt = pc + pc_off;
  assign reg_sum = base + sext_reg(imm_field);
  assign reg_tgt = clear_lsb(reg_sum);

  always_comb begin
    redirect = 1'b0;
    link_en  = 1'b0;
    target   = seq_pc;
    unique case (xclass)
      XC_BRANCH: begin
        redirect = cond_true;
        target   = cond_true ? pcrel_tgt : seq_pc;
      end
      XC_JAL: begin
        redirect = 1'b1;
        link_en  = 1'b1;
        target   = pcrel_tgt;
      end
      XC_JALR: begin
        redirect = 1'b1;
        link_en  = 1'b1;
        target   = reg_tgt;
      end
      default: begin
        redirect = 1'b0;
        target   = seq_pc;
      end
    endcase
  end

endmodule

// File: rtl/rv_xfer_unit.sv
module rv_xfer_unit #(
  parameter int              XLEN       = 32,
  parameter int              BR_IMM_W   = 12,
  parameter int              J_IMM_W    = 20,
  parameter int              I_IMM_W    = 12,
  parameter int              INSN_BYTES = 4,
  parameter bit              CMP_SUB    = 1'b1,
  parameter logic [XLEN-1:0] RESET_PC   = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    rs1_val,
  input  logic [XLEN-1:0]    rs2_val,
  input  logic [J_IMM_W-1:0] imm_field,
  input  logic [1:0]         xfer_class,
  input  logic [2:0]         cond,
  output logic               out_valid,
  output logic [XLEN-1:0]    next_pc,
  output logic               taken,
  output logic [XLEN-1:0]    link_val,
  output logic               link_we
);
  import xfer_pkg::*;

  // Internal events, named for the assertions below.
  logic            ev_eq;
  logic            ev_lt_s;
  logic            ev_lt_u;
  logic            ev_cond;
  logic [XLEN-1:0] ev_seq;
  logic [XLEN-1:0] ev_pcrel;
  logic [XLEN-1:0] ev_regtgt;
  logic [XLEN-1:0] ev_target;
  logic            ev_redirect;
  logic            ev_link;

  xfer_cond_eval #(
    .XLEN    (XLEN),
    .CMP_SUB (CMP_SUB)
  ) u_cond (
    .opa       (rs1_val),
    .opb       (rs2_val),
    .cond      (cond),
    .op_eq     (ev_eq),
    .op_lt_s   (ev_lt_s),
    .op_lt_u   (ev_lt_u),
    .cond_true (ev_cond)
  );

  xfer_target_gen #(
    .XLEN       (XLEN),
    .BR_IMM_W   (BR_IMM_W),
    .J_IMM_W    (J_IMM_W),
    .I_IMM_W    (I_IMM_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_tgt (
    .pc        (pc),
    .base      (rs1_val),
    .imm_field (imm_field),
    .xclass    (xfer_class),
    .cond_true (ev_cond),
    .seq_pc    (ev_seq),
    .pcrel_tgt (ev_pcrel),
    .reg_tgt   (ev_regtgt),
    .target    (ev_target),
    .redirect  (ev_redirect),
    .link_en   (ev_link)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      next_pc   <= RESET_PC;
      taken     <= 1'b0;
      link_val  <= '0;
      link_we   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc  <= ev_target;
        taken    <= ev_redirect;
        link_val <= ev_seq;
        link_we  <= ev_link;
      end
    end
  end

  // R8
  branch_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xfer_class == XC_BRANCH) |=> !link_we);

  // R8
  jump_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xfer_class[1]) |=> (link_we && taken && link_val == $past(pc) + XLEN'(INSN_BYTES)));

  // R9
  seq_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xfer_class == XC_NONE) |=> (!taken && next_pc == $past(pc) + XLEN'(INSN_BYTES)));

  // R7
  jalr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xfer_class == XC_JALR) |=> (next_pc[0] == 1'b0));

  // R10
  reserved_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xfer_class == XC_BRANCH && cond[2:1] == 2'b01) |=> !taken);

  // R2
  not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xfer_class == XC_BRANCH && !ev_cond) |=> (!taken && next_pc == $past(pc) + XLEN'(INSN_BYTES)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken) && $stable(link_val) && $stable(link_we)));

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

endmodule

// File: tb/tb_rv_xfer_unit.sv
`timescale 1ns/1ps
module tb_rv_xfer_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] pc = '0;
  logic [31:0] rs1_val = '0;
  logic [31:0] rs2_val = '0;
  logic [19:0] imm_field = '0;
  logic [1:0]  xfer_class = '0;
  logic [2:0]  cond = '0;
  logic        out_valid;
  logic [31:0] next_pc;
  logic        taken;
  logic [31:0] link_val;
  logic        link_we;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rv_xfer_unit dut (
    .clk, .rst_n, .in_valid, .pc, .rs1_val, .rs2_val, .imm_field,
    .xfer_class, .cond, .out_valid, .next_pc, .taken, .link_val, .link_we
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=%0d cycles expected=finish", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int br_off(logic [19:0] f);
    int v = int'(f[11:0]);
    if (v >= 2048) v -= 4096;
    return v * 2;
  endfunction

  function automatic int jal_off(logic [19:0] f);
    int v = int'(f);
    if (v >= 524288) v -= 1048576;
    return v * 2;
  endfunction

  function automatic int jalr_off(logic [19:0] f);
    int v = int'(f[11:0]);
    if (v >= 2048) v -= 4096;
    return v;
  endfunction

  function automatic bit cond_holds(logic [2:0] c, logic [31:0] a, logic [31:0] b);
    int sa = a;
    int sb = b;
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return sa < sb;
      3'b101: return sa >= sb;
      3'b110: return {1'b0, a} < {1'b0, b};
      3'b111: return {1'b0, a} >= {1'b0, b};
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] k, logic [2:0] c);
    if (k == 2'b00) return "R9";
    if (k == 2'b10) return "R6";
    if (k == 2'b11) return "R7";
    if (c[2:1] == 2'b00) return "R2";
    if (c[2:1] == 2'b10) return "R3";
    if (c[2:1] == 2'b11) return "R4";
    return "R10";
  endfunction

  task automatic run_one(logic [31:0] p, logic [31:0] a, logic [31:0] b,
                         logic [19:0] f, logic [1:0] k, logic [2:0] c, string tag);
    logic [31:0] exp_pc;
    bit          exp_tk;
    @(negedge clk);
    in_valid = 1'b1; pc = p; rs1_val = a; rs2_val = b;
    imm_field = f; xfer_class = k; cond = c;
    exp_tk = 1'b0;
    exp_pc = p + 32'd4;
    case (k)
      2'b01: if (cond_holds(c, a, b)) begin exp_tk = 1'b1; exp_pc = p + 32'(br_off(f)); end
      2'b10: begin exp_tk = 1'b1; exp_pc = p + 32'(jal_off(f)); end
      2'b11: begin exp_tk = 1'b1; exp_pc = (a + 32'(jalr_off(f))) & 32'hFFFF_FFFE; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    check({tag, " taken"}, {31'd0, taken}, {31'd0, exp_tk});
    check({tag, " next_pc"}, next_pc, exp_pc);
    check("R8 link_we", {31'd0, link_we}, {31'd0, k[1]});
    if (k[1]) check("R8 link_val", link_val, p + 32'd4);
    check("R11 out_valid", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 taken", {31'd0, taken}, 32'd0);
    check("R1 link_we", {31'd0, link_we}, 32'd0);
    check("R1 next_pc", next_pc, 32'd0);
    check("R1 link_val", link_val, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle next_pc", next_pc, 32'd0);

    // Directed corner cases.
    run_one(32'h0000_2000, 32'd5, 32'd5, 20'h00010, 2'b01, 3'b000, "R2");
    run_one(32'h0000_2000, 32'd5, 32'd6, 20'h00010, 2'b01, 3'b000, "R2");
    run_one(32'h0000_2000, 32'hFFFF_FFFF, 32'd1, 20'h00008, 2'b01, 3'b100, "R3");
    run_one(32'h0000_2000, 32'hFFFF_FFFF, 32'd1, 20'h00008, 2'b01, 3'b110, "R4");
    run_one(32'h0000_2000, 32'h8000_0000, 32'h7FFF_FFFF, 20'h00008, 2'b01, 3'b101, "R3");
    run_one(32'h0000_2000, 32'h8000_0000, 32'h7FFF_FFFF, 20'h00008, 2'b01, 3'b111, "R4");
    run_one(32'h0001_0000, 32'd1, 32'd1, 20'h00800, 2'b01, 3'b000, "R5 min");
    run_one(32'h0001_0000, 32'd1, 32'd1, 20'h007FF, 2'b01, 3'b000, "R5 max");
    run_one(32'h0001_0000, 32'd1, 32'd1, 20'hFF800, 2'b01, 3'b000, "R5 upper bits");
    run_one(32'h0040_0000, 32'd0, 32'd0, 20'h80000, 2'b10, 3'b000, "R6 min");
    run_one(32'h0040_0000, 32'd0, 32'd0, 20'h7FFFF, 2'b10, 3'b000, "R6 max");
    run_one(32'h0000_1000, 32'h1234_5679, 32'd0, 20'hFF000, 2'b11, 3'b000, "R7 odd");
    run_one(32'h0000_1000, 32'h0000_0100, 32'd0, 20'h00F00, 2'b11, 3'b000, "R7 neg");
    run_one(32'h0000_3000, 32'd7, 32'd7, 20'h00040, 2'b01, 3'b010, "R10");
    run_one(32'h0000_3000, 32'd7, 32'd8, 20'h00040, 2'b01, 3'b011, "R10");
    run_one(32'hFFFF_FFFC, 32'd0, 32'd0, 20'h00040, 2'b00, 3'b000, "R9 wrap");

    // Hold: change inputs with in_valid low; outputs must keep the last result.
    run_one(32'h0000_5000, 32'd0, 32'd0, 20'h00100, 2'b10, 3'b000, "R6");
    @(negedge clk);
    in_valid = 1'b0; pc = 32'h0BAD_0000; xfer_class = 2'b00; imm_field = 20'h00004;
    @(posedge clk); #1;
    check("R11 hold out_valid", {31'd0, out_valid}, 32'd0);
    check("R11 hold next_pc", next_pc, 32'h0000_5200);
    check("R11 hold taken", {31'd0, taken}, 32'd1);
    check("R11 hold link_we", {31'd0, link_we}, 32'd1);
    check("R11 hold link_val", link_val, 32'h0000_5004);

    // Constrained random traffic.
    for (int i = 0; i < 400; i++) begin
      logic [31:0] p, a, b;
      logic [19:0] f;
      logic [1:0]  k;
      logic [2:0]  c;
      p = {$urandom(), 2'b00} >> 0;
      p = {p[31:2], 2'b00};
      a = $urandom();
      b = ($urandom_range(0, 3) == 0) ? a : $urandom();
      if ($urandom_range(0, 3) == 0) b = {~a[31], a[30:0]};
      f = 20'($urandom());
      k = 2'($urandom_range(0, 3));
      c = 3'($urandom_range(0, 7));
      run_one(p, a, b, f, k, c, tag_of(k, c));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule